// File: doc/BRIEF.md
# Dynamic Bus Sizing Cycle Splitter

This block sits between a 32-bit processor core and its external bus. The core hands it one transfer at a time. A transfer is a word address, four byte enables, a direction and a flag that says whether burst continuation is acceptable. The block then runs that transfer on the bus. In every data cycle the addressed device may report that it serves only 8 or 16 bits. When it does, the block breaks the transfer into further sub-cycles until every requested byte lane has been moved.

Each sub-cycle presents only the byte lanes that are still outstanding. A narrow device moves the lowest lane (8-bit) or the lower halfword (16-bit) first. The last-cycle output tracks whether the ready being answered will close the transfer. Read bytes from each sub-cycle are collected into a 32-bit holding word, which is handed back to the core with a one-cycle done pulse. A normal ready starts the next sub-cycle with a fresh address strobe. A burst ready continues without a strobe, but only where a burst is permitted. Writes may burst only when a narrow width was reported.

Top module: `dynsize_seq`

## Requirements
- R1: When `reqReady` is high and `reqValid` is high with at least one byte enable set at a clock edge, the request is accepted. In the next cycle `busStrobe` is high for exactly one cycle. `busAddr`, `busWrite` and `busWData` carry the request values for the whole transfer.
- R2: `busReady` and `busBurstReady` count only in the data phase, which is the cycles after a strobe. In the strobe cycle they are ignored. The size inputs are sampled at the same edge as the ready they go with. When `busSize8` and `busSize16` are both high, the 8-bit width wins.
- R3: With `busSize8` high, a ready serves only the lowest-numbered pending lane. Lane i is data bits 8i+7..8i and byte-enable bit i.
- R4: With only `busSize16` high, a ready serves the pending lanes among lanes 0-1 if any are pending. Otherwise it serves the pending lanes among lanes 2-3.
- R5: With neither size input high, a ready serves all pending lanes, and the transfer ends.
- R6: During a sub-cycle, `busByteEn` shows exactly the lanes still pending. It loses the served lanes after each ready that does not end the transfer.
- R7: `busLast` is high in the data phase exactly when the current size inputs would let a ready finish the transfer. It is low outside the data phase.
- R8: For reads, each served lane captures its byte of `busRData` into the holding word. Lanes not requested read as zero. `doneRData` carries the merged word while `doneValid` is high.
- R9: A normal ready (alone, or together with burst ready) that leaves lanes pending is followed in the next cycle by a new strobe.
- R10: A burst ready alone that leaves lanes pending continues in the data phase with no strobe. This holds for a read with the burst flag set, or for a write with the burst flag set and a narrow width sampled at that edge.
- R11: A burst ready in any other case behaves like a normal ready: a new strobe follows.
- R12: `doneValid` is a one-cycle pulse in the cycle after the final ready. `reqReady` is low from acceptance until that cycle. A request with all byte enables clear is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Core offers a transfer |
| reqAddr | input | ADDR_W (30) | Word address of the transfer |
| reqByteEn | input | 4 | Requested byte lanes, bit i = lane i |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqBurstOk | input | 1 | Burst continuation is permitted |
| reqWData | input | 32 | Write data, lane aligned |
| reqReady | output | 1 | Block idle and able to accept |
| doneValid | output | 1 | Transfer finished (one-cycle pulse) |
| doneRData | output | 32 | Merged read word |
| busStrobe | output | 1 | Address strobe, one cycle per new bus cycle |
| busAddr | output | ADDR_W (30) | Bus word address |
| busByteEn | output | 4 | Pending byte lanes, active high |
| busWrite | output | 1 | Bus direction |
| busWData | output | 32 | Bus write data |
| busLast | output | 1 | This ready ends the transfer |
| busReady | input | 1 | Normal ready from the device |
| busBurstReady | input | 1 | Burst ready from the device |
| busSize8 | input | 1 | Device serves 8 bits this cycle |
| busSize16 | input | 1 | Device serves 16 bits this cycle |
| busRData | input | 32 | Bus read data |

## Verification
The strobe appears in the cycle after the accepting edge. The first ready is counted no earlier than the edge that ends the strobe cycle. `doneValid` and the merged word show in the cycle after the final ready, and the done pulse is gone one cycle later. `busByteEn` and `busLast` are combinational in the data phase, so the bench drives the size and ready inputs at the falling edge, lets them settle, and samples before the rising edge that consumes them. Every other result is sampled at the falling edge one cycle after the rising edge that should produce it. A deliberate ready in the strobe cycle shows that nothing happens early.

// File: rtl/dynsize_pkg.sv
package dynsize_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;    // capture a new request
    logic serve;   // a counted ready: retire served lanes
    logic finish;  // the counted ready ends the transfer
  } ctrlStb_t;

endpackage

// File: rtl/dynsize_ctrl.sv
module dynsize_ctrl
  import dynsize_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANE_N = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [LANE_N-1:0] reqByteEn,
  input  logic              busReady,
  input  logic              busBurstReady,
  input  logic              lastChunk,
  input  logic              burstLegal,
  output ctrlStb_t          stb,
  output logic              busStrobe,
  output logic              dataPhase,
  output logic              reqReady
);

  seqState_e stateQ, stateD;
  logic      readyAny;
  logic      burstGo;

  assign readyAny = busReady | busBurstReady;
  // normal ready wins over burst ready when both are present
  assign burstGo  = busBurstReady & ~busReady & burstLegal;

  always_comb begin
    stateD     = stateQ;
    stb        = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (reqValid && (|reqByteEn)) begin
          stb.load = 1'b1;
          stateD   = ST_ADDR;
        end
      end
      ST_ADDR: begin
        stateD = ST_DATA;
      end
      ST_DATA: begin
        if (readyAny) begin
          stb.serve = 1'b1;
          if (lastChunk) begin
            stb.finish = 1'b1;
            stateD     = ST_IDLE;
          end else if (burstGo) begin
            stateD = ST_DATA;
          end else begin
            stateD = ST_ADDR;
          end
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign busStrobe = (stateQ == ST_ADDR);
  assign dataPhase = (stateQ == ST_DATA);
  assign reqReady  = (stateQ == ST_IDLE);

endmodule

// File: rtl/dynsize_dpath.sv
module dynsize_dpath
  import dynsize_pkg::*;
#(
  parameter int ADDR_W = 30,
  parameter int DATA_W = 32,
  localparam int LANE_N = DATA_W / 8,
  localparam int HALF_N = LANE_N / 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStb_t          stb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LANE_N-1:0] reqByteEn,
  input  logic              reqWrite,
  input  logic              reqBurstOk,
  input  logic [DATA_W-1:0] reqWData,
  input  logic              busSize8,
  input  logic              busSize16,
  input  logic [DATA_W-1:0] busRData,
  output logic [ADDR_W-1:0] busAddr,
  output logic [LANE_N-1:0] busByteEn,
  output logic              busWrite,
  output logic [DATA_W-1:0] busWData,
  output logic              lastChunk,
  output logic              burstLegal,
  output logic              doneValid,
  output logic [DATA_W-1:0] doneRData
);

  logic [ADDR_W-1:0] addrQ;
  logic              writeQ;
  logic              burstOkQ;
  logic [DATA_W-1:0] wdataQ;
  logic [LANE_N-1:0] pendQ;
  logic [DATA_W-1:0] holdQ;
  logic              doneQ;

  logic [LANE_N-1:0] lowByte;
  logic [LANE_N-1:0] lowHalf;
  logic [LANE_N-1:0] served;
  logic              narrow;

  // lowest pending lane (8-bit device)
  always_comb begin
    lowByte = '0;
    for (int i = LANE_N - 1; i >= 0; i--) begin
      if (pendQ[i]) begin
        lowByte    = '0;
        lowByte[i] = 1'b1;
      end
    end
  end

  // lowest halfword holding a pending lane (16-bit device)
  always_comb begin
    lowHalf = '0;
    for (int h = HALF_N - 1; h >= 0; h--) begin
      if (|pendQ[2*h +: 2]) begin
        lowHalf         = '0;
        lowHalf[2*h +: 2] = pendQ[2*h +: 2];
      end
    end
  end

  always_comb begin
    if (busSize8)       served = lowByte;
    else if (busSize16) served = lowHalf;
    else                served = pendQ;
  end

  assign narrow     = busSize8 | busSize16;
  assign lastChunk  = ((pendQ & ~served) == '0);
  assign burstLegal = burstOkQ & (~writeQ | narrow);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ    <= '0;
      writeQ   <= 1'b0;
      burstOkQ <= 1'b0;
      wdataQ   <= '0;
      pendQ    <= '0;
    end else if (stb.load) begin
      addrQ    <= reqAddr;
      writeQ   <= reqWrite;
      burstOkQ <= reqBurstOk;
      wdataQ   <= reqWData;
      pendQ    <= reqByteEn;
    end else if (stb.serve) begin
      pendQ    <= pendQ & ~served;
    end
  end

  // per-lane read merge into the holding word
  generate
    for (genvar g = 0; g < LANE_N; g++) begin : gLane
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          holdQ[8*g +: 8] <= '0;
        end else if (stb.load) begin
          holdQ[8*g +: 8] <= '0;
        end else if (stb.serve && served[g] && !writeQ) begin
          holdQ[8*g +: 8] <= busRData[8*g +: 8];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) doneQ <= 1'b0;
    else       doneQ <= stb.finish;
  end

  assign busAddr   = addrQ;
  assign busByteEn = pendQ;
  assign busWrite  = writeQ;
  assign busWData  = wdataQ;
  assign doneValid = doneQ;
  assign doneRData = holdQ;

endmodule

// File: rtl/dynsize_seq.sv
module dynsize_seq
  import dynsize_pkg::*;
#(
  parameter int ADDR_W = 30,
  parameter int DATA_W = 32,
  localparam int LANE_N = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LANE_N-1:0] reqByteEn,
  input  logic              reqWrite,
  input  logic              reqBurstOk,
  input  logic [DATA_W-1:0] reqWData,
  output logic              reqReady,
  output logic              doneValid,
  output logic [DATA_W-1:0] doneRData,
  output logic              busStrobe,
  output logic [ADDR_W-1:0] busAddr,
  output logic [LANE_N-1:0] busByteEn,
  output logic              busWrite,
  output logic [DATA_W-1:0] busWData,
  output logic              busLast,
  input  logic              busReady,
  input  logic              busBurstReady,
  input  logic              busSize8,
  input  logic              busSize16,
  input  logic [DATA_W-1:0] busRData
);

  ctrlStb_t stb;
  logic     lastChunk;
  logic     burstLegal;
  logic     dataPhase;

  dynsize_ctrl #(.DATA_W(DATA_W)) uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .reqByteEn    (reqByteEn),
    .busReady     (busReady),
    .busBurstReady(busBurstReady),
    .lastChunk    (lastChunk),
    .burstLegal   (burstLegal),
    .stb          (stb),
    .busStrobe    (busStrobe),
    .dataPhase    (dataPhase),
    .reqReady     (reqReady)
  );

  dynsize_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uDpath (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .reqAddr   (reqAddr),
    .reqByteEn (reqByteEn),
    .reqWrite  (reqWrite),
    .reqBurstOk(reqBurstOk),
    .reqWData  (reqWData),
    .busSize8  (busSize8),
    .busSize16 (busSize16),
    .busRData  (busRData),
    .busAddr   (busAddr),
    .busByteEn (busByteEn),
    .busWrite  (busWrite),
    .busWData  (busWData),
    .lastChunk (lastChunk),
    .burstLegal(burstLegal),
    .doneValid (doneValid),
    .doneRData (doneRData)
  );

  assign busLast = dataPhase & lastChunk;

endmodule

// File: rtl/dynsize_chk.sv
module dynsize_chk #(
  parameter int LANE_N = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              busStrobe,
  input logic [LANE_N-1:0] busByteEn,
  input logic              busLast,
  input logic              busReady,
  input logic              busBurstReady,
  input logic              busSize8,
  input logic              doneValid,
  input logic              reqReady,
  input logic              dataPhase
);

  logic rdyAny;
  assign rdyAny = busReady | busBurstReady;

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    busStrobe |=> !busStrobe); // R1

  AST_STROBE_HAS_LANES: assert property (@(posedge clk) disable iff (!rstN)
    busStrobe |-> (busByteEn != '0)); // R6

  AST_LANES_SHRINK: assert property (@(posedge clk) disable iff (!rstN)
    (dataPhase && rdyAny && !busLast) |=>
      (((busByteEn & ~$past(busByteEn)) == '0) && (busByteEn != $past(busByteEn)))); // R6

  AST_BYTE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (dataPhase && rdyAny && busSize8 && !busLast) |=>
      ($countones($past(busByteEn)) == $countones(busByteEn) + 1)); // R3

  AST_FINAL_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (dataPhase && rdyAny && busLast) |=> doneValid); // R7

  AST_NORMAL_RESTROBE: assert property (@(posedge clk) disable iff (!rstN)
    (dataPhase && busReady && !busLast) |=> busStrobe); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid); // R12

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    (busStrobe || dataPhase) |-> !reqReady); // R12

  AST_LAST_IN_DATA: assert property (@(posedge clk) disable iff (!rstN)
    busLast |-> dataPhase); // R7

endmodule

bind dynsize_seq dynsize_chk #(.LANE_N(LANE_N)) uChk (
  .clk          (clk),
  .rstN         (rstN),
  .busStrobe    (busStrobe),
  .busByteEn    (busByteEn),
  .busLast      (busLast),
  .busReady     (busReady),
  .busBurstReady(busBurstReady),
  .busSize8     (busSize8),
  .doneValid    (doneValid),
  .reqReady     (reqReady),
  .dataPhase    (dataPhase)
);

// File: tb/sim_dynsize_seq.sv
`timescale 1ns/1ps
module sim_dynsize_seq;

  localparam int ADDR_W = 30;
  localparam int DATA_W = 32;
  localparam int LANE_N = DATA_W / 8;
  localparam int WD_NS  = 200000;

  typedef struct packed {
    logic [3:0]  be;
    logic        wr;
    logic        bok;
    logic [2:0]  n;       // sub-cycles
    logic [7:0]  sz;      // per sub-cycle: bit1 = size8, bit0 = size16
    logic [3:0]  rk;      // per sub-cycle: 1 = burst ready, 0 = normal ready
    logic [15:0] expBe;   // expected byte enables per sub-cycle
    logic [2:0]  expStr;  // expected strobes
    logic [31:0] expRd;   // expected merged read word
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{4'hF, 1'b0, 1'b0, 3'd1, 8'h00, 4'h0, 16'h000F, 3'd1, 32'hA0A0A0A0}, // R5 full width
    '{4'h7, 1'b0, 1'b0, 3'd3, 8'h2A, 4'h0, 16'h0467, 3'd3, 32'h00A2A1A0}, // R3 three bytes
    '{4'hF, 1'b0, 1'b1, 3'd4, 8'hAA, 4'hF, 16'h8CEF, 3'd1, 32'hA3A2A1A0}, // R10 read burst
    '{4'hF, 1'b1, 1'b1, 3'd4, 8'hAA, 4'hF, 16'h8CEF, 3'd1, 32'h00000000}, // R10 write burst
    '{4'hF, 1'b1, 1'b0, 3'd4, 8'hAA, 4'hF, 16'h8CEF, 3'd4, 32'h00000000}, // R11 write no flag
    '{4'hF, 1'b0, 1'b0, 3'd2, 8'h05, 4'h0, 16'h00CF, 3'd2, 32'hA1A1A0A0}, // R4 halves
    '{4'hF, 1'b0, 1'b0, 3'd3, 8'h29, 4'h0, 16'h08CF, 3'd3, 32'hA2A1A0A0}, // R6 mixed widths
    '{4'hF, 1'b0, 1'b0, 3'd2, 8'h03, 4'h0, 16'h00EF, 3'd2, 32'hA1A1A1A0}, // R2 both sizes
    '{4'hC, 1'b0, 1'b0, 3'd1, 8'h01, 4'h0, 16'h000C, 3'd1, 32'hA0A00000}, // R4 upper only
    '{4'h6, 1'b0, 1'b0, 3'd2, 8'h05, 4'h0, 16'h0046, 3'd2, 32'h00A1A000}, // R4 straddle
    '{4'hA, 1'b1, 1'b0, 3'd2, 8'h0A, 4'h0, 16'h008A, 3'd2, 32'h00000000}, // R3 sparse write
    '{4'hF, 1'b1, 1'b1, 3'd2, 8'h01, 4'h3, 16'h00CF, 3'd1, 32'h00000000}, // R10 narrow then full
    '{4'hF, 1'b0, 1'b0, 3'd4, 8'hAA, 4'hF, 16'h8CEF, 3'd4, 32'hA3A2A1A0}, // R11 read no flag
    '{4'hF, 1'b0, 1'b1, 3'd2, 8'h05, 4'h3, 16'h00CF, 3'd1, 32'hA1A1A0A0}  // R8 burst halves
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [LANE_N-1:0] reqByteEn = '0;
  logic              reqWrite = 1'b0;
  logic              reqBurstOk = 1'b0;
  logic [DATA_W-1:0] reqWData = '0;
  logic              reqReady;
  logic              doneValid;
  logic [DATA_W-1:0] doneRData;
  logic              busStrobe;
  logic [ADDR_W-1:0] busAddr;
  logic [LANE_N-1:0] busByteEn;
  logic              busWrite;
  logic [DATA_W-1:0] busWData;
  logic              busLast;
  logic              busReady = 1'b0;
  logic              busBurstReady = 1'b0;
  logic              busSize8 = 1'b0;
  logic              busSize16 = 1'b0;
  logic [DATA_W-1:0] busRData = '0;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  dynsize_seq u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqByteEn(reqByteEn), .reqWrite(reqWrite), .reqBurstOk(reqBurstOk),
    .reqWData(reqWData), .reqReady(reqReady), .doneValid(doneValid),
    .doneRData(doneRData), .busStrobe(busStrobe), .busAddr(busAddr),
    .busByteEn(busByteEn), .busWrite(busWrite), .busWData(busWData),
    .busLast(busLast), .busReady(busReady), .busBurstReady(busBurstReady),
    .busSize8(busSize8), .busSize16(busSize16), .busRData(busRData)
  );

  task automatic check(input logic ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic runVec(input int idx, input vec_t v);
    int strobes = 0;
    int sub = 0;
    logic [ADDR_W-1:0] a = ADDR_W'(32'h0100_0000 + idx * 4);
    logic [DATA_W-1:0] wd = 32'h5A00_0000 | DATA_W'(idx);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqByteEn = v.be; reqWrite = v.wr;
    reqBurstOk = v.bok; reqWData = wd;
    @(negedge clk);
    reqValid = 1'b0; reqByteEn = '0;
    check(busAddr == a && busWrite == v.wr && busWData == wd, "R1", "request fields",
          {busWrite, 1'b0, busAddr}, {v.wr, 1'b0, a});
    check(reqReady == 1'b0, "R12", "busy", reqReady, 0);
    while (sub < int'(v.n)) begin
      if (busStrobe) begin
        strobes++;
        @(negedge clk);
      end
      busSize8      = v.sz[sub*2 + 1];
      busSize16     = v.sz[sub*2];
      busBurstReady = v.rk[sub];
      busReady      = ~v.rk[sub];
      busRData      = {4{8'hA0 + 8'(sub)}};
      #1;
      check(busByteEn == v.expBe[sub*4 +: 4], "R6", "pending lanes",
            busByteEn, v.expBe[sub*4 +: 4]);
      check(busLast == (sub == int'(v.n) - 1), "R7", "last indicator",
            busLast, (sub == int'(v.n) - 1));
      @(negedge clk);
      busReady = 1'b0; busBurstReady = 1'b0; busSize8 = 1'b0; busSize16 = 1'b0;
      sub++;
    end
    check(strobes == int'(v.expStr), "R9", "strobe count (R10 R11)", strobes, v.expStr);
    check(doneValid == 1'b1, "R12", "done pulse", doneValid, 1);
    if (!v.wr)
      check(doneRData == v.expRd, "R8", "merged read", doneRData, v.expRd);
    @(negedge clk);
    check(doneValid == 1'b0 && reqReady == 1'b1, "R12", "pulse ends",
          {doneValid, reqReady}, 2'b01);
  endtask

  initial begin
    #(WD_NS * 1ns);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state
    check(busStrobe == 0 && doneValid == 0 && reqReady == 1 && busLast == 0,
          "R12", "reset outputs", {busStrobe, doneValid, reqReady, busLast}, 4'b0010);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) runVec(i, VECS[i]);

    // zero byte enables are ignored
    reqValid = 1'b1; reqByteEn = '0; reqWrite = 1'b0;
    @(negedge clk);
    reqValid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      check(busStrobe == 0 && reqReady == 1, "R12", "empty request ignored",
            {busStrobe, reqReady}, 2'b01);
      @(negedge clk);
    end

    // ready during the strobe cycle is ignored
    reqValid = 1'b1; reqByteEn = 4'hF; reqWrite = 1'b0; reqBurstOk = 1'b0;
    @(negedge clk);
    reqValid = 1'b0;
    check(busStrobe == 1, "R1", "strobe after accept", busStrobe, 1);
    busReady = 1'b1; busRData = 32'h1234_5678;
    @(negedge clk);
    check(doneValid == 0 && busStrobe == 0 && reqReady == 0, "R2",
          "early ready ignored", {doneValid, busStrobe, reqReady}, 3'b000);
    @(negedge clk);
    busReady = 1'b0;
    check(doneValid == 1 && doneRData == 32'h1234_5678, "R2", "ready in data phase",
          doneRData, 32'h1234_5678);
    @(negedge clk);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule